// File: doc/BRIEF.md
# Frequency Boost Level Controller

This block picks the clock frequency level for a chip built from several compute modules. It offers three levels. The base level is the normal operating point. The all-module boost applies to every active module whenever there is power headroom. The maximum boost is allowed only when software asks for peak performance and at least half of the modules are in deep sleep. In that case the power budget freed by the sleeping modules goes to the modules still awake.

Three flags and a sleep vector drive the choice. The over-limit flag says that a power or thermal limit has been reached. The headroom flag says there is margin left under those limits. The performance-request flag asks for peak speed, and the sleep vector has one bit per module. The block does not move the clock by itself. Each change is offered to the clock and voltage logic as a request, and the new level becomes current only once that logic acknowledges it. A programmable dwell time spaces out level increases. Decreases are never delayed. The block also drives a per-module clock-enable mask that gates off every sleeping module.

Top module: `boost_level_ctrl`

## Requirements
- R1: During and right after reset, `curLevel` is 0, `chgReq` is low and `clkEnMask` is all zeros.
- R2: The level code is 0 for base, 1 for all-module boost and 2 for maximum boost; `curLevel` never shows code 3. With headroom, no over-limit and no eligibility for maximum boost, the target is level 1.
- R3: Eligibility for level 2 requires `perfReq` high and a count of set `sleepVec` bits of at least ceil(N/2). Without eligibility, headroom yields level 1, and a current level 2 is lowered to 1.
- R4: `overLimit` overrides every other input. On the first clock edge where it is high and the level is above 0, the block presents a request for level 0. If a request is already pending, that request is retargeted to level 0 on that edge.
- R5: `chgReq` and `reqLevel` hold until `chgAck` is sampled high. `curLevel` takes the requested value on that same edge and on no other edge.
- R6: After a level change is committed with dwell value D, a request that raises the level cannot rise before D+1 clock edges have passed. A request that lowers the level is issued on the next edge, whatever the dwell.
- R7: On each edge, each bit of `clkEnMask` takes the inverse of the matching `sleepVec` bit. This holds at every level.
- R8: With neither headroom nor over-limit, the level is never raised. It stays where it is, apart from the R3 drop from level 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| overLimit | input | 1 | A power or thermal limit has been reached |
| headroom | input | 1 | Margin exists below the limits |
| perfReq | input | 1 | Peak performance requested |
| sleepVec | input | NUM_MODULES | One bit per module, set while that module is in deep sleep |
| dwellCycles | input | DWELL_W | Minimum number of cycles after a change before the next increase |
| chgAck | input | 1 | Clock/voltage logic has applied the requested level |
| chgReq | output | 1 | A level change is pending |
| reqLevel | output | 2 | Level being requested |
| curLevel | output | 2 | Level currently in force |
| clkEnMask | output | NUM_MODULES | Per-module clock enable |

## Verification
The bench builds the block with four modules and an 8-bit dwell field. With four modules the eligibility threshold falls exactly at two sleepers, so the bench can drive both one sleeper and two sleepers. It runs with a dwell of 5, which makes the spacing of increases measurable in cycles while a decrease still goes out at once. It also runs with a dwell of 0, the boundary where an increase may follow a commit on the very next edge. Acknowledges are held back on purpose, which keeps a request pending long enough to retarget it with an over-limit.

// File: rtl/boost_level_pkg.sv
package boost_level_pkg;

  typedef enum logic [1:0] {
    LVL_BASE = 2'd0,
    LVL_ALL  = 2'd1,
    LVL_MAX  = 2'd2
  } levelE;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic loadReq;    // capture the desired level as the pending request
    logic forceBase;  // retarget the pending request to base
    logic commit;     // acknowledged: pending request becomes current
  } strobeT;

endpackage

// File: rtl/boost_level_dp.sv
module boost_level_dp
  import boost_level_pkg::*;
#(
  parameter int NUM_MODULES = 4,
  parameter int DWELL_W     = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   overLimit,
  input  logic                   headroom,
  input  logic                   perfReq,
  input  logic [NUM_MODULES-1:0] sleepVec,
  input  logic [DWELL_W-1:0]     dwellCycles,
  input  strobeT                 strb,
  output logic                   wantUp,
  output logic                   wantDown,
  output logic                   dwellDone,
  output logic                   reqNonZero,
  output levelE                  curLvl,
  output levelE                  reqLvl,
  output logic [NUM_MODULES-1:0] clkEnMask
);

  localparam int CNT_W = $clog2(NUM_MODULES + 1);
  localparam int HALF  = (NUM_MODULES + 1) / 2;

  logic [CNT_W-1:0]   sleepCnt;
  logic               maxOk;
  levelE              ceilLvl;
  levelE              desired;
  logic [DWELL_W-1:0] dwellCnt;

  always_comb begin
    sleepCnt = '0;
    for (int i = 0; i < NUM_MODULES; i++) begin
      sleepCnt = sleepCnt + CNT_W'(sleepVec[i]);
    end
  end

  assign maxOk   = perfReq && (sleepCnt >= CNT_W'(HALF));
  assign ceilLvl = maxOk ? LVL_MAX : LVL_ALL;

  always_comb begin
    if (overLimit) begin
      desired = LVL_BASE;
    end else if (headroom) begin
      desired = ceilLvl;
    end else if (curLvl > ceilLvl) begin
      desired = ceilLvl;
    end else begin
      desired = curLvl;
    end
  end

  assign wantUp     = desired > curLvl;
  assign wantDown   = desired < curLvl;
  assign dwellDone  = (dwellCnt == '0);
  assign reqNonZero = (reqLvl != LVL_BASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqLvl <= LVL_BASE;
    end else if (strb.loadReq) begin
      reqLvl <= desired;
    end else if (strb.forceBase) begin
      reqLvl <= LVL_BASE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLvl <= LVL_BASE;
    end else if (strb.commit) begin
      curLvl <= reqLvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dwellCnt <= '0;
    end else if (strb.commit) begin
      dwellCnt <= dwellCycles;
    end else if (dwellCnt != '0) begin
      dwellCnt <= dwellCnt - 1'b1;
    end
  end

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clkEnMask[m] <= 1'b0;
      end else begin
        clkEnMask[m] <= ~sleepVec[m];
      end
    end
  end

  // an increase may only be captured once the dwell window is empty (R6)
  p_dwell_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadReq && desired > curLvl) |-> dwellCnt == '0);

  // a sleeping module never keeps its clock (R7)
  p_sleep_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (clkEnMask & $past(sleepVec)) == '0);

  // maximum boost is only ever requested when eligible (R3)
  p_max_eligible_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadReq && !overLimit) |=> (reqLvl != LVL_MAX) || $past(perfReq));

endmodule

// File: rtl/boost_level_fsm.sv
module boost_level_fsm
  import boost_level_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   wantUp,
  input  logic   wantDown,
  input  logic   dwellDone,
  input  logic   overLimit,
  input  logic   reqNonZero,
  input  logic   chgAck,
  output strobeT strb,
  output logic   chgReq
);

  typedef enum logic {ST_IDLE, ST_WAIT} stateE;
  stateE state, stateNxt;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (wantDown || (wantUp && dwellDone)) begin
          strb.loadReq = 1'b1;
          stateNxt     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (chgAck) begin
          strb.commit = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (overLimit && reqNonZero) begin
          strb.forceBase = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNxt;
    end
  end

  assign chgReq = (state == ST_WAIT);

  // a pending request is dropped only by an acknowledge (R5)
  p_req_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (chgReq && !chgAck) |=> chgReq);

  // an acknowledge always ends the pending request (R5)
  p_ack_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    (chgReq && chgAck) |=> !chgReq);

endmodule

// File: rtl/boost_level_ctrl.sv
module boost_level_ctrl
  import boost_level_pkg::*;
#(
  parameter int NUM_MODULES = 4,
  parameter int DWELL_W     = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   overLimit,
  input  logic                   headroom,
  input  logic                   perfReq,
  input  logic [NUM_MODULES-1:0] sleepVec,
  input  logic [DWELL_W-1:0]     dwellCycles,
  input  logic                   chgAck,
  output logic                   chgReq,
  output logic [1:0]             reqLevel,
  output logic [1:0]             curLevel,
  output logic [NUM_MODULES-1:0] clkEnMask
);

  strobeT strb;
  logic   wantUp, wantDown, dwellDone, reqNonZero;
  levelE  curLvl, reqLvl;

  boost_level_dp #(
    .NUM_MODULES(NUM_MODULES),
    .DWELL_W    (DWELL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .overLimit  (overLimit),
    .headroom   (headroom),
    .perfReq    (perfReq),
    .sleepVec   (sleepVec),
    .dwellCycles(dwellCycles),
    .strb       (strb),
    .wantUp     (wantUp),
    .wantDown   (wantDown),
    .dwellDone  (dwellDone),
    .reqNonZero (reqNonZero),
    .curLvl     (curLvl),
    .reqLvl     (reqLvl),
    .clkEnMask  (clkEnMask)
  );

  boost_level_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .wantUp    (wantUp),
    .wantDown  (wantDown),
    .dwellDone (dwellDone),
    .overLimit (overLimit),
    .reqNonZero(reqNonZero),
    .chgAck    (chgAck),
    .strb      (strb),
    .chgReq    (chgReq)
  );

  assign reqLevel = reqLvl;
  assign curLevel = curLvl;

  // the level code 3 is never in force (R2)
  p_level_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    curLevel != 2'd3);

  // the current level moves only on an acknowledged request (R5)
  p_cur_on_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(chgReq && chgAck) |=> $stable(curLevel));

  // idle with a raised level: over-limit brings a base request at once (R4)
  p_overlimit_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (overLimit && !chgReq && curLevel != 2'd0) |=> chgReq && reqLevel == 2'd0);

  // pending request without ack: over-limit retargets it to base (R4)
  p_overlimit_retarget_r4: assert property (@(posedge clk) disable iff (!rstN)
    (overLimit && chgReq && !chgAck) |=> chgReq && reqLevel == 2'd0);

endmodule

// File: tb/boost_level_ctrl_bench.sv
module boost_level_ctrl_bench;

  localparam int N  = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          overLimit = 1'b0, headroom = 1'b0, perfReq = 1'b0, chgAck = 1'b0;
  logic [N-1:0]  sleepVec = '0;
  logic [DW-1:0] dwellCycles = 8'd5;
  logic          chgReq;
  logic [1:0]    reqLevel, curLevel;
  logic [N-1:0]  clkEnMask;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  int expQ[$];
  logic [1:0] prevCur = 2'd0;

  boost_level_ctrl #(.NUM_MODULES(N), .DWELL_W(DW)) u_boost_level_ctrl (
    .clk(clk), .rstN(rstN), .overLimit(overLimit), .headroom(headroom),
    .perfReq(perfReq), .sleepVec(sleepVec), .dwellCycles(dwellCycles),
    .chgAck(chgAck), .chgReq(chgReq), .reqLevel(reqLevel),
    .curLevel(curLevel), .clkEnMask(clkEnMask)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finishRun();
    end
  end

  // scoreboard monitor: every change of the current level pops one expectation
  always @(negedge clk) begin
    if (rstN && curLevel != prevCur) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected level change", int'(curLevel), int'(prevCur));
      end else begin
        int e;
        e = expQ.pop_front();
        check(int'(curLevel) == e, "R5 committed level", int'(curLevel), e);
      end
    end
    prevCur <= curLevel;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns the number of low samples seen before chgReq goes high
  task automatic waitReq(output int lowCnt);
    lowCnt = 0;
    forever begin
      @(negedge clk);
      if (chgReq || lowCnt > 200) break;
      lowCnt++;
    end
  endtask

  task automatic doAck();
    chgAck = 1'b1;
    @(negedge clk);
    chgAck = 1'b0;
  endtask

  initial begin
    int lc;
    tick(3);
    check(curLevel == 2'd0, "R1 reset level", int'(curLevel), 0);
    check(chgReq == 1'b0, "R1 reset request", int'(chgReq), 0);
    check(clkEnMask == '0, "R1 reset mask", int'(clkEnMask), 0);
    rstN = 1'b1;
    tick(2);
    check(chgReq == 1'b0 && curLevel == 2'd0, "R1 idle after reset", int'(chgReq), 0);

    // R2: headroom alone gives all-module boost
    headroom = 1'b1;
    expQ.push_back(1);
    waitReq(lc);
    check(lc == 0, "R2 request latency", lc, 0);
    check(reqLevel == 2'd1, "R2 requested level", int'(reqLevel), 1);
    tick(2);
    check(chgReq == 1'b1, "R5 request held", int'(chgReq), 1);
    check(curLevel == 2'd0, "R5 level before ack", int'(curLevel), 0);
    doAck();
    check(curLevel == 2'd1, "R5 level after ack", int'(curLevel), 1);
    check(chgReq == 1'b0, "R5 request cleared", int'(chgReq), 0);

    // R6 dwell before increase, R3 maximum boost with half asleep
    sleepVec = 4'b0011;
    perfReq  = 1'b1;
    expQ.push_back(2);
    waitReq(lc);
    check(lc == 5, "R6 dwell before increase", lc, 5);
    check(reqLevel == 2'd2, "R3 max boost requested", int'(reqLevel), 2);
    check(clkEnMask == 4'b1100, "R7 mask at level 1", int'(clkEnMask), 12);
    doAck();
    check(curLevel == 2'd2, "R3 max boost current", int'(curLevel), 2);

    // R3 one sleeper is not enough; R6 decrease is immediate
    sleepVec = 4'b0001;
    expQ.push_back(1);
    waitReq(lc);
    check(lc == 0, "R6 decrease not delayed", lc, 0);
    check(reqLevel == 2'd1, "R3 drop on lost eligibility", int'(reqLevel), 1);
    check(clkEnMask == 4'b1110, "R7 mask at level 2", int'(clkEnMask), 14);
    doAck();

    // R3 without perfReq no maximum boost
    sleepVec = 4'b0011;
    perfReq  = 1'b0;
    tick(12);
    check(chgReq == 1'b0, "R3 no request without perfReq", int'(chgReq), 0);
    check(curLevel == 2'd1, "R3 stays at level 1", int'(curLevel), 1);

    // R8 no increase without headroom
    headroom = 1'b0;
    perfReq  = 1'b1;
    tick(12);
    check(chgReq == 1'b0, "R8 no increase without headroom", int'(chgReq), 0);
    check(curLevel == 2'd1, "R8 level held", int'(curLevel), 1);

    // R8 level 2 falls to 1 without headroom once modules wake
    headroom = 1'b1;
    expQ.push_back(2);
    waitReq(lc);
    doAck();
    headroom = 1'b0;
    sleepVec = 4'b0000;
    expQ.push_back(1);
    waitReq(lc);
    check(lc == 0 && reqLevel == 2'd1, "R8 drop from level 2", int'(reqLevel), 1);
    check(clkEnMask == 4'b1111, "R7 mask all awake", int'(clkEnMask), 15);
    doAck();

    // R4 over-limit request to base
    overLimit = 1'b1;
    expQ.push_back(0);
    waitReq(lc);
    check(lc == 0, "R4 drop latency", lc, 0);
    check(reqLevel == 2'd0, "R4 base requested", int'(reqLevel), 0);
    doAck();
    check(curLevel == 2'd0, "R4 base current", int'(curLevel), 0);

    // R4 pending increase retargeted by over-limit
    overLimit = 1'b0;
    headroom  = 1'b1;
    sleepVec  = 4'b0011;
    waitReq(lc);
    check(reqLevel == 2'd2, "R4 pending increase", int'(reqLevel), 2);
    overLimit = 1'b1;
    tick(1);
    check(chgReq == 1'b1 && reqLevel == 2'd0, "R4 retargeted to base", int'(reqLevel), 0);
    doAck();
    check(curLevel == 2'd0, "R4 level stays base", int'(curLevel), 0);

    // R6 zero dwell: increase on the next edge after commit
    dwellCycles = 8'd0;
    overLimit   = 1'b0;
    perfReq     = 1'b0;
    expQ.push_back(1);
    waitReq(lc);
    doAck();
    perfReq = 1'b1;
    expQ.push_back(2);
    waitReq(lc);
    check(lc == 0, "R6 zero dwell", lc, 0);
    doAck();

    tick(2);
    check(expQ.size() == 0, "R5 all expected changes seen", expQ.size(), 0);
    done = 1'b1;
    finishRun();
  end

endmodule